// File: doc/BRIEF.md
# UART Receive Status Flags and Clear Sequencer

This block keeps the status and error flags of a UART receiver and decides when each one is set and when it is cleared. A receive engine sits in front of it. That engine reports a finished byte together with several qualifiers: the stop bit was low, parity was wrong, noise was seen, or a break character arrived. It also reports a separate idle detection. The block holds the accepted byte and flags an overrun when a byte arrives while the previous one is still unread. It raises a receive-data request that goes either to a DMA channel or to the CPU, and it raises a separate error interrupt.

Two kinds of reader can clear flags, and they are handled differently. A DMA read of the data register clears only the receive-full flag. A CPU clears flags with a status read followed by a data read. The status read moves a small sequencer from `SEQ_IDLE` to `SEQ_ARMED` and takes a snapshot of the flags. The transition `ARM` happens on a status read, and a later status read in `SEQ_ARMED` takes the snapshot again. The following CPU data read fires the transition `CLEAR` back to `SEQ_IDLE` and clears exactly the flags in the snapshot. Software drops the receive interrupt enable while it runs this sequence, so the DMA cannot take a byte partway through.

Top module: `rx_status_ctl`

## Requirements
- R1: A byte completion while the full flag (`flags[0]`) is clear sets the full flag and loads `rx_byte` onto `data_q` one cycle later.
- R2: An accepted byte sets the following flags from its qualifiers: noise sets `flags[4]`, a low stop bit sets `flags[5]`, bad parity sets `flags[6]`, and break sets `flags[2]`. An `rx_idle` pulse sets `flags[1]`.
- R3: A byte completion while the full flag is set and not being cleared that cycle sets the overrun flag `flags[3]`. That byte is discarded, along with its qualifiers, and `data_q` keeps the held byte.
- R4: A DMA data read clears the full flag and leaves `flags[6:1]` unchanged.
- R5: Error and status flags are sticky and accumulate over several bytes until the CPU clear sequence runs.
- R6: A CPU status read followed by a CPU data read clears every flag that was set at the status read, including the full flag.
- R7: A flag that becomes set after the status read survives the data read that completes the sequence.
- R8: A DMA data read while armed neither completes the sequence nor clears error flags. The next CPU data read still completes it.
- R9: `dma_req` equals full AND `rie` AND `dma_mode`. `rx_irq` equals full AND `rie` AND NOT `dma_mode`. With `rie` low, neither is asserted.
- R10: `err_irq` is the OR of overrun, noise, framing and parity, each ANDed with `err_ie[0]`, `err_ie[1]`, `err_ie[2]` and `err_ie[3]` in that order. It stays high until the flags are cleared.
- R11: A byte completion in the same cycle as a data read that clears the full flag is accepted: `data_q` takes the new byte, full stays set, and no overrun is flagged.
- R12: A CPU data read with the sequencer not armed clears no flag.
- R13: If the full flag is cleared by DMA while the sequencer is armed, a byte that arrives afterwards keeps its full flag through the completing CPU data read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Receive engine finished a byte |
| rx_byte | input | DW | Received byte |
| rx_stop_low | input | 1 | Stop bit sampled low for this byte |
| rx_par_bad | input | 1 | Parity mismatch for this byte |
| rx_noise | input | 1 | Noise detected in this byte |
| rx_brk | input | 1 | Byte was a break character |
| rx_idle | input | 1 | Idle line detected (pulse) |
| cpu_stat_rd | input | 1 | CPU status-register read strobe |
| cpu_data_rd | input | 1 | CPU data-register read strobe |
| dma_data_rd | input | 1 | DMA data-register read strobe |
| rie | input | 1 | Receive interrupt/DMA request enable |
| dma_mode | input | 1 | Route the receive request to DMA (1) or CPU (0) |
| err_ie | input | 4 | Error enables: overrun, noise, framing, parity |
| data_q | output | DW | Held received byte |
| flags | output | 7 | Flag vector, bit 0 full up to bit 6 parity |
| dma_req | output | 1 | DMA service request |
| rx_irq | output | 1 | CPU receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The byte-completion path and the flag-clearing path can act in the same cycle. The bench provokes this by pulsing `rx_done` on the same edge as a DMA data read, and separately by letting a new byte set a flag between the arming status read and the completing CPU data read. The outcome is judged at the ports. A byte that meets a clearing read is accepted, with its value on `data_q`, full still set and no overrun. Flags set after the snapshot survive the completing read while the snapshot flags disappear.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int NFLAG  = 7;
    localparam int F_FULL = 0;
    localparam int F_IDLE = 1;
    localparam int F_BRK  = 2;
    localparam int F_OVR  = 3;
    localparam int F_NF   = 4;
    localparam int F_FE   = 5;
    localparam int F_PE   = 6;
    localparam int NERR   = F_PE - F_OVR + 1;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;
endpackage

// File: rtl/rxs_clr_seq.sv
module rxs_clr_seq
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_rd,
    input  logic             cpu_rd,
    input  logic             dma_full_clr,
    input  logic [NFLAG-1:0] flags_q,
    output logic [NFLAG-1:0] cpu_clr_vec,
    output logic             armed
);
    seq_state_t       state_q, state_nx;
    logic [NFLAG-1:0] snap_q;
    logic             do_clear;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_nx;
    end

    // Transitions: ARM on status read, CLEAR on CPU data read while armed
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (stat_rd) state_nx = SEQ_ARMED;
            SEQ_ARMED: if (cpu_rd)  state_nx = SEQ_IDLE;
            default:   state_nx = SEQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        armed       = (state_q == SEQ_ARMED);
        do_clear    = armed & cpu_rd;
        cpu_clr_vec = do_clear ? snap_q : '0;
    end

    // Snapshot of flags taken at the arming status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (do_clear) begin
            snap_q <= '0;
        end else if (stat_rd) begin
            snap_q <= flags_q;
        end else if (armed && dma_full_clr) begin
            snap_q[F_FULL] <= 1'b0;
        end
    end
endmodule

// File: rtl/rxs_flag_bank.sv
module rxs_flag_bank
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic [NFLAG-1:0] clr_vec,
    output logic [NFLAG-1:0] flags_q
);
    // Set wins over clear in the same cycle
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (set_vec[i]) flags_q[i] <= 1'b1;
            else if (clr_vec[i]) flags_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rxs_req_route.sv
module rxs_req_route
    import rxs_pkg::*;
(
    input  logic            full,
    input  logic            rie,
    input  logic            dma_mode,
    input  logic [NERR-1:0] err_flags,
    input  logic [NERR-1:0] err_ie,
    output logic            dma_req,
    output logic            rx_irq,
    output logic            err_irq
);
    logic [NERR-1:0] err_masked;

    for (genvar i = 0; i < NERR; i++) begin : g_mask
        assign err_masked[i] = err_flags[i] & err_ie[i];
    end

    assign dma_req = full & rie & dma_mode;
    assign rx_irq  = full & rie & ~dma_mode;
    assign err_irq = |err_masked;
endmodule

// File: rtl/rx_status_ctl.sv
module rx_status_ctl
    import rxs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_stop_low,
    input  logic          rx_par_bad,
    input  logic          rx_noise,
    input  logic          rx_brk,
    input  logic          rx_idle,
    input  logic          cpu_stat_rd,
    input  logic          cpu_data_rd,
    input  logic          dma_data_rd,
    input  logic          rie,
    input  logic          dma_mode,
    input  logic [3:0]    err_ie,
    output logic [DW-1:0] data_q,
    output logic [6:0]    flags,
    output logic          dma_req,
    output logic          rx_irq,
    output logic          err_irq
);
    logic [NFLAG-1:0] flag_q, set_vec, clr_vec, cpu_clr_vec, dma_clr_vec;
    logic [DW-1:0]    hold_q;
    logic             armed, dma_full_clr, accept, ovr_hit;

    always_comb begin
        dma_clr_vec         = '0;
        dma_clr_vec[F_FULL] = dma_data_rd;
    end

    assign dma_full_clr = dma_data_rd & flag_q[F_FULL];
    assign clr_vec      = cpu_clr_vec | dma_clr_vec;
    assign accept       = rx_done & (~flag_q[F_FULL] | clr_vec[F_FULL]);
    assign ovr_hit      = rx_done & ~accept;

    always_comb begin
        set_vec         = '0;
        set_vec[F_FULL] = accept;
        set_vec[F_IDLE] = rx_idle;
        set_vec[F_BRK]  = accept & rx_brk;
        set_vec[F_OVR]  = ovr_hit;
        set_vec[F_NF]   = accept & rx_noise;
        set_vec[F_FE]   = accept & rx_stop_low;
        set_vec[F_PE]   = accept & rx_par_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (accept) hold_q <= rx_byte;
    end

    rxs_clr_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_rd     (cpu_stat_rd),
        .cpu_rd      (cpu_data_rd),
        .dma_full_clr(dma_full_clr),
        .flags_q     (flag_q),
        .cpu_clr_vec (cpu_clr_vec),
        .armed       (armed)
    );

    rxs_flag_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .flags_q(flag_q)
    );

    rxs_req_route u_route (
        .full     (flag_q[F_FULL]),
        .rie      (rie),
        .dma_mode (dma_mode),
        .err_flags(flag_q[F_PE:F_OVR]),
        .err_ie   (err_ie),
        .dma_req  (dma_req),
        .rx_irq   (rx_irq),
        .err_irq  (err_irq)
    );

    assign data_q = hold_q;
    assign flags  = flag_q;
endmodule

// File: rtl/rx_status_chk.sv
module rx_status_chk
    import rxs_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_done,
    input logic          cpu_data_rd,
    input logic          dma_data_rd,
    input logic          armed,
    input logic [6:0]    flags,
    input logic [DW-1:0] data_q,
    input logic          dma_req,
    input logic          rx_irq,
    input logic          err_irq,
    input logic          rie
);
    // R3: overrun keeps the held byte
    a_r3_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && flags[F_FULL] && !dma_data_rd && !(armed && cpu_data_rd))
        |=> (flags[F_OVR] && $stable(data_q)));

    // R4: DMA read drops the full flag when no byte lands
    a_r4_dma_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_data_rd && !rx_done) |=> !flags[F_FULL]);

    // R5: without a completing CPU read, flags 6..1 never fall
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && cpu_data_rd)
        |=> ((flags[F_PE:F_IDLE] & $past(flags[F_PE:F_IDLE])) == $past(flags[F_PE:F_IDLE])));

    // R9: requests need the enable and a full buffer, never both at once
    a_r9_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req || rx_irq) |-> (rie && flags[F_FULL]));
    a_r9_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_req, rx_irq}));

    // R10: error interrupt only with an error flag
    a_r10_irq_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (|flags[F_PE:F_OVR]));

    // R12: unarmed CPU data read clears nothing
    a_r12_unarmed_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && cpu_data_rd && !dma_data_rd)
        |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind rx_status_ctl rx_status_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_done    (rx_done),
    .cpu_data_rd(cpu_data_rd),
    .dma_data_rd(dma_data_rd),
    .armed      (armed),
    .flags      (flags),
    .data_q     (data_q),
    .dma_req    (dma_req),
    .rx_irq     (rx_irq),
    .err_irq    (err_irq),
    .rie        (rie)
);

// File: tb/rx_status_ctl_test.sv
module rx_status_ctl_test;
    localparam int CLK_P = 10;
    localparam logic [6:0] FULL = 7'h01, IDLE = 7'h02, BRK = 7'h04, OVR = 7'h08,
                           NF = 7'h10, FE = 7'h20, PE = 7'h40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_done, rx_stop_low, rx_par_bad, rx_noise, rx_brk, rx_idle;
    logic [7:0] rx_byte;
    logic       cpu_stat_rd, cpu_data_rd, dma_data_rd, rie, dma_mode;
    logic [3:0] err_ie;
    logic [7:0] data_q;
    logic [6:0] flags;
    logic       dma_req, rx_irq, err_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rx_status_ctl #(.DW(8)) uut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
        .rx_stop_low(rx_stop_low), .rx_par_bad(rx_par_bad), .rx_noise(rx_noise),
        .rx_brk(rx_brk), .rx_idle(rx_idle), .cpu_stat_rd(cpu_stat_rd),
        .cpu_data_rd(cpu_data_rd), .dma_data_rd(dma_data_rd), .rie(rie),
        .dma_mode(dma_mode), .err_ie(err_ie), .data_q(data_q), .flags(flags),
        .dma_req(dma_req), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_done = 0; rx_byte = 0; rx_stop_low = 0; rx_par_bad = 0; rx_noise = 0;
        rx_brk = 0; rx_idle = 0; cpu_stat_rd = 0; cpu_data_rd = 0; dma_data_rd = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; idle_inputs(); rie = 0; dma_mode = 0; err_ie = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    task automatic rx_in(input logic [7:0] d, input bit fe, input bit pe, input bit nf, input bit bk);
        @(negedge clk);
        rx_done = 1; rx_byte = d; rx_stop_low = fe; rx_par_bad = pe; rx_noise = nf; rx_brk = bk;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic stat_rd();
        @(negedge clk); cpu_stat_rd = 1; @(negedge clk); idle_inputs();
    endtask

    task automatic cpu_rd();
        @(negedge clk); cpu_data_rd = 1; @(negedge clk); idle_inputs();
    endtask

    task automatic dma_rd();
        @(negedge clk); dma_data_rd = 1; @(negedge clk); idle_inputs();
    endtask

    task automatic t_reset();
        do_reset();
        check("reset flags", flags, 0);
        check("reset data", data_q, 0);
        check("reset irqs", {dma_req, rx_irq, err_irq}, 0);
    endtask

    task automatic t_receive();
        do_reset();
        rx_in(8'hA5, 0, 0, 0, 0);
        check("R1 full set", flags, FULL);
        check("R1 data", data_q, 8'hA5);
        dma_rd();
        rx_in(8'h3C, 1, 1, 1, 0);
        check("R2 fe pe nf", flags, FULL | FE | PE | NF);
        do_reset();
        rx_in(8'h00, 0, 0, 0, 1);
        @(negedge clk); rx_idle = 1; @(negedge clk); idle_inputs();
        check("R2 brk idle", flags, FULL | BRK | IDLE);
    endtask

    task automatic t_overrun();
        do_reset();
        rx_in(8'h11, 0, 0, 0, 0);
        rx_in(8'h22, 1, 0, 0, 0);
        check("R3 overrun flags", flags, FULL | OVR);
        check("R3 held byte", data_q, 8'h11);
    endtask

    task automatic t_dma_sticky();
        do_reset();
        rx_in(8'h01, 1, 0, 0, 0);
        dma_rd();
        check("R4 dma clears full only", flags, FE);
        rx_in(8'h02, 0, 1, 0, 0);
        dma_rd();
        check("R5 errors accumulate", flags, FE | PE);
    endtask

    task automatic t_cpu_clear();
        do_reset();
        rx_in(8'h05, 1, 0, 1, 0);
        stat_rd();
        cpu_rd();
        check("R6 two-read clear", flags, 0);
    endtask

    task automatic t_late_flag();
        do_reset();
        rx_in(8'h06, 1, 0, 0, 0);
        dma_rd();
        stat_rd();
        rx_in(8'h07, 0, 1, 0, 0);
        cpu_rd();
        check("R7 late flags survive", flags, FULL | PE);
        check("R7 data", data_q, 8'h07);
    endtask

    task automatic t_dma_no_complete();
        do_reset();
        rx_in(8'h08, 1, 0, 0, 0);
        stat_rd();
        dma_rd();
        check("R8 dma while armed", flags, FE);
        cpu_rd();
        check("R8 cpu completes", flags, 0);
    endtask

    task automatic t_route();
        do_reset();
        rx_in(8'h09, 0, 0, 0, 0);
        rie = 1; dma_mode = 1; #1;
        check("R9 dma route", {dma_req, rx_irq}, 2'b10);
        dma_mode = 0; #1;
        check("R9 cpu route", {dma_req, rx_irq}, 2'b01);
        rie = 0; #1;
        check("R9 rie low", {dma_req, rx_irq}, 2'b00);
    endtask

    task automatic t_err_irq();
        do_reset();
        rx_in(8'h0A, 1, 0, 0, 0);
        err_ie = 4'b1011; #1;
        check("R10 fe masked", err_irq, 0);
        err_ie = 4'b0100; #1;
        check("R10 fe enabled", err_irq, 1);
        dma_rd();
        check("R10 held", err_irq, 1);
        stat_rd(); cpu_rd();
        check("R10 released", err_irq, 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        rx_in(8'h11, 0, 0, 0, 0);
        @(negedge clk);
        rx_done = 1; rx_byte = 8'h33; dma_data_rd = 1;
        @(negedge clk);
        idle_inputs();
        check("R11 flags", flags, FULL);
        check("R11 data", data_q, 8'h33);
    endtask

    task automatic t_unarmed();
        do_reset();
        rx_in(8'h0B, 0, 1, 0, 0);
        cpu_rd();
        check("R12 unarmed read", flags, FULL | PE);
    endtask

    task automatic t_snap_drop();
        do_reset();
        rx_in(8'h0C, 0, 0, 0, 0);
        stat_rd();
        dma_rd();
        rx_in(8'h0D, 0, 0, 0, 0);
        cpu_rd();
        check("R13 new full kept", flags, FULL);
        check("R13 data", data_q, 8'h0D);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_inputs(); rie = 0; dma_mode = 0; err_ie = 0;
        t_reset();
        t_receive();
        t_overrun();
        t_dma_sticky();
        t_cpu_clear();
        t_late_flag();
        t_dma_no_complete();
        t_route();
        t_err_irq();
        t_same_cycle();
        t_unarmed();
        t_snap_drop();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule